// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock Controller

This block is the ground-referenced control logic for one half-bridge leg. It receives two switch commands, one for the high-side switch and one for the low-side switch, with opposite polarities. It also receives one undervoltage flag for each supply domain. From these it produces two enables, one for each output driver. The two enables are never high together.

Each command is registered once, and any pattern that asks for both switches is discarded at that register. The low-side request then passes through a delay line. This line stands in for the latency that the high-side signal picks up downstream in level shifting. A turn-on is granted only after the opposite enable has stayed low for a programmable dead time. The dead time for a low-to-high transition and the dead time for a high-to-low transition are set independently, in clock cycles.

Each undervoltage flag is the output of an external hysteresis comparator and is sampled as a plain logic level. Low-side undervoltage removes both enables. High-side undervoltage removes only the high-side enable.

Top module: `hb_interlock`

## Requirements
- R1: `hs_cmd_n` is active low: 0 requests the high-side switch. `ls_cmd` is active high: 1 requests the low-side switch.
- R2: `hs_en` and `ls_en` are never 1 in the same cycle.
- R3: A sampled command pair with `hs_cmd_n`=0 and `ls_cmd`=1 is discarded. The last legal request stays in force: an enabled switch stays enabled, and from idle neither enable rises.
- R4: With `uv_lo`=1 at a clock edge, both enables are 0 after that edge.
- R5: With `uv_hi`=1 at a clock edge, `hs_en` is 0 after that edge. `ls_en` still follows `ls_cmd`.
- R6: From a settled idle state, `hs_en` rises on the second clock edge after `hs_cmd_n` falls.
- R7: From a settled idle state, `ls_en` rises on edge 2+`LS_DLY` after `ls_cmd` rises.
- R8: `hs_en` rises only after `ls_en` has been 0 for at least `DT_LH` cycles. When the commands switch together from low-on to high-on, `ls_en` falls on edge 2+`LS_DLY` and `hs_en` rises `DT_LH`+1 edges later.
- R9: `ls_en` rises only after `hs_en` has been 0 for at least `DT_HL` cycles. When the commands switch together from high-on to low-on, `hs_en` falls on edge 2 and `ls_en` rises `DT_HL`+1 edges after that.
- R10: The active-low reset `rst_n` clears both enables at once, without waiting for a clock. While both undervoltage flags stay asserted, both enables stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd_n | input | 1 | High-side command, active low |
| ls_cmd | input | 1 | Low-side command, active high |
| uv_lo | input | 1 | Low-side supply undervoltage flag |
| uv_hi | input | 1 | High-side supply undervoltage flag |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |

## Verification
The bench builds the block with `DT_LH`=4, `DT_HL`=3 and `LS_DLY`=2. These values are small and unequal, so the edge at which each turn-on lands can be told apart by exact cycle in both switching directions. They also keep every transition short enough that a vector table can let each command pattern settle in 16 cycles. The low-side delay of two stages is what allows the bench to observe the low-side enable still high while the high-side request is already registered.

// File: rtl/hb_interlock.sv
`timescale 1ns/1ps
module hb_interlock #(
  parameter int DT_LH  = 22,
  parameter int DT_HL  = 15,
  parameter int LS_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd_n,
  input  logic ls_cmd,
  input  logic uv_lo,
  input  logic uv_hi,
  output logic hs_en,
  output logic ls_en
);
  localparam int CMAX = (DT_LH > DT_HL) ? DT_LH : DT_HL;
  localparam int CW   = (CMAX < 1) ? 1 : $clog2(CMAX + 1);
  localparam logic [CW-1:0] LH_C  = CW'(DT_LH);
  localparam logic [CW-1:0] HL_C  = CW'(DT_HL);
  localparam logic [CW-1:0] SAT_C = CW'(CMAX);

  logic hs_req, both_req;
  logic rq_hs, rq_ls, ls_want;
  logic [CW-1:0] hs_off, ls_off;
  logic go_hs, go_ls;

  assign hs_req   = ~hs_cmd_n;
  assign both_req = hs_req & ls_cmd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rq_hs <= 1'b0;
      rq_ls <= 1'b0;
    end else if (!both_req) begin
      rq_hs <= hs_req;
      rq_ls <= ls_cmd;
    end

  generate
    if (LS_DLY == 0) begin : g_nodly
      assign ls_want = rq_ls;
    end else begin : g_dly
      logic [LS_DLY-1:0] sh;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= (sh << 1) | LS_DLY'(rq_ls);
      assign ls_want = sh[LS_DLY-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_off <= '0;
      ls_off <= '0;
    end else begin
      hs_off <= hs_en ? '0 : ((hs_off == SAT_C) ? hs_off : hs_off + 1'b1);
      ls_off <= ls_en ? '0 : ((ls_off == SAT_C) ? ls_off : ls_off + 1'b1);
    end

  assign go_hs = rq_hs & ~ls_en & ~ls_want & (ls_off >= LH_C);
  assign go_ls = ls_want & ~hs_en & ~rq_hs & (hs_off >= HL_C);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      hs_en <= rq_hs & ~uv_lo & ~uv_hi & (hs_en | go_hs);
      ls_en <= ls_want & ~uv_lo & (ls_en | go_ls);
    end
endmodule

module hb_interlock_chk #(
  parameter int DT_LH = 22,
  parameter int DT_HL = 15
) (
  input logic clk,
  input logic rst_n,
  input logic uv_lo,
  input logic uv_hi,
  input logic hs_en,
  input logic ls_en
);
  logic [15:0] ls_gap, hs_gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ls_gap <= '0;
      hs_gap <= '0;
    end else begin
      ls_gap <= ls_en ? '0 : ((ls_gap == 16'hFFFF) ? ls_gap : ls_gap + 16'd1);
      hs_gap <= hs_en ? '0 : ((hs_gap == 16'hFFFF) ? hs_gap : hs_gap + 16'd1);
    end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));
  a_r4_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_lo |=> (!hs_en && !ls_en));
  a_r5_uvhi_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hi |=> !hs_en);
  a_r8_gap_lh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (32'(ls_gap) >= DT_LH));
  a_r9_gap_hl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> (32'(hs_gap) >= DT_HL));
endmodule

bind hb_interlock hb_interlock_chk #(.DT_LH(DT_LH), .DT_HL(DT_HL)) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_lo(uv_lo), .uv_hi(uv_hi),
  .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/hb_interlock_bench.sv
`timescale 1ns/1ps
module hb_interlock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_cmd_n = 1'b1, ls_cmd = 1'b0, uv_lo = 1'b1, uv_hi = 1'b1;
  logic hs_en, ls_en;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hb_interlock #(.DT_LH(4), .DT_HL(3), .LS_DLY(2)) u_hb_interlock (
    .clk(clk), .rst_n(rst_n), .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd),
    .uv_lo(uv_lo), .uv_hi(uv_hi), .hs_en(hs_en), .ls_en(ls_en)
  );

  // {hs_cmd_n, ls_cmd, uv_lo, uv_hi, exp_hs, exp_ls}
  localparam logic [5:0] VEC [0:14] = '{
    6'b0_0_1_1_0_0,  // R10 flags held
    6'b1_0_0_0_0_0,  // idle
    6'b0_0_0_0_1_0,  // R1 high-side active low
    6'b0_1_0_0_1_0,  // R3 both: keep high
    6'b1_1_0_0_0_1,  // R1 low-side active high
    6'b0_1_0_0_0_1,  // R3 both: keep low
    6'b0_1_0_1_0_1,  // R5
    6'b0_0_0_1_0_0,  // R5 high blocked
    6'b1_1_0_1_0_1,  // R5 low unaffected
    6'b1_1_1_0_0_0,  // R4
    6'b0_0_1_0_0_0,  // R4
    6'b0_0_0_0_1_0,  // R1
    6'b1_0_0_0_0_0,  // idle
    6'b0_1_0_0_0_0,  // R3 both from idle
    6'b1_0_0_0_0_0   // idle
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic h, input logic l, input logic ul, input logic uh);
    hs_cmd_n = h; ls_cmd = l; uv_lo = ul; uv_hi = uh;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #5;
    chk("R10 reset hs", hs_en, 1'b0);
    chk("R10 reset ls", ls_en, 1'b0);
    edges(3);
    rst_n = 1'b1;
    edges(2);

    for (int i = 0; i < 15; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      edges(16);
      chk($sformatf("R1/R3/R4/R5 vec%0d hs", i), hs_en, VEC[i][1]);
      chk($sformatf("R1/R3/R4/R5 vec%0d ls", i), ls_en, VEC[i][0]);
      chk("R2 exclusive", hs_en & ls_en, 1'b0);
    end

    // R6 latency of high side from idle
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    edges(1); chk("R6 hs after 1", hs_en, 1'b0);
    edges(1); chk("R6 hs after 2", hs_en, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    edges(16);

    // R7 latency of low side from idle
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    edges(3); chk("R7 ls after 3", ls_en, 1'b0);
    edges(1); chk("R7 ls after 4", ls_en, 1'b1);
    edges(12);

    // R8 low-on to high-on
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    edges(3); chk("R8 ls after 3", ls_en, 1'b1);
    edges(1); chk("R8 ls after 4", ls_en, 1'b0);
    edges(4); chk("R8 hs after 8", hs_en, 1'b0);
    edges(1); chk("R8 hs after 9", hs_en, 1'b1);
    edges(8);

    // R9 high-on to low-on
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    edges(1); chk("R9 hs after 1", hs_en, 1'b1);
    edges(1); chk("R9 hs after 2", hs_en, 1'b0);
    edges(3); chk("R9 ls after 5", ls_en, 1'b0);
    edges(1); chk("R9 ls after 6", ls_en, 1'b1);
    edges(8);

    // R4 immediate removal on low-side undervoltage
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    edges(1); chk("R4 ls after 1", ls_en, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    edges(16);

    // R5 immediate removal on high-side undervoltage, recovery
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    edges(1); chk("R5 hs after 1", hs_en, 1'b0);
    chk("R5 ls stays off", ls_en, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    edges(1); chk("R5 hs returns", hs_en, 1'b1);

    // R10 asynchronous reset while enabled
    #3 rst_n = 1'b0;
    #1 chk("R10 async hs", hs_en, 1'b0);
    chk("R10 async ls", ls_en, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule